// File: doc/BRIEF.md
# Bus Slave Register Select Interface

This block is the slave-side front end of a block-transfer controller on a parallel processor bus. It watches an active-low bus strobe. When the word address on the bus falls inside the controller's strapped window, it works out which of four internal registers is being accessed and whether the access is a read or a write. It then drives the matching per-register control line.

A write to the control, address or block-length register produces a load enable of fixed width and a one-cycle capture strobe, with the bus data word latched alongside. A write to the status register does not store anything. It acts as a command and produces a clear pulse of the same fixed width for the transfer control path. A read holds the output enable of the selected register for as long as the bus strobe stays asserted.

The strobe and write lines are brought into the clock domain through a two-stage synchroniser. The address and data lines are assumed stable for the whole strobe. Each strobe assertion yields at most one pulse, however long it is held.

Top module: `bus_regsel_if`

## Requirements
- R1: A strobe produces outputs only when address bits 15..3 equal `strap_addr` and address bits 15..12 are all ones. Any other strobe leaves every output low and `wr_data` unchanged.
- R2: Address bits {2,1} select the register: 00 status, 11 control, 01 address register (bit 1 high, bit 2 low), 10 block length (bit 1 low, bit 2 high).
- R3: A write to the control, address or block-length register raises only that register's load line (`ld_ctrl`, `ld_addr`, `ld_blen`) for exactly PULSE_CYC cycles. The load line is first high after the third rising clock edge that sees `bus_strb_n` low.
- R4: A write to the status register raises `clr_pulse` for exactly PULSE_CYC cycles with the same start timing as R3. It raises no load line or capture strobe and leaves `wr_data` unchanged.
- R5: `cap_stb` is high for exactly one cycle, the first cycle of each load window of R3.
- R6: A read raises only the selected register's output enable from the same cycle as R3. It holds until the third rising edge that sees `bus_strb_n` high again. Reads and writes never overlap.
- R7: One strobe assertion yields one pulse. Holding the strobe longer neither extends nor repeats a load or clear pulse, and a one-cycle strobe still yields a full-width pulse.
- R8: On an accepted write to control, address or block length, `wr_data` takes the value of `bus_data` and holds it until the next such write.
- R9: While `rst_n` is low at a rising edge, all outputs are low and `wr_data` is zero after that edge.
- R10: `bus_wr_n` low (active) marks a write and high marks a read. The level is taken through the same synchroniser as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 15 | Bus word address, bits 15..1 |
| bus_data | input | 16 | Bus data word |
| bus_wr_n | input | 1 | Active-low write qualifier |
| bus_strb_n | input | 1 | Active-low bus strobe |
| strap_addr | input | 13 | Strapped device address compared with bits 15..3 |
| wr_data | output | 16 | Data word latched on register writes |
| ld_ctrl | output | 1 | Control register load enable |
| ld_addr | output | 1 | Address register load enable |
| ld_blen | output | 1 | Block-length register load enable |
| cap_stb | output | 1 | One-cycle register capture strobe |
| clr_pulse | output | 1 | Transfer control clear pulse (status write) |
| rd_stat_oe | output | 1 | Status register read output enable |
| rd_ctrl_oe | output | 1 | Control register read output enable |
| rd_addr_oe | output | 1 | Address register read output enable |
| rd_blen_oe | output | 1 | Block-length register read output enable |

## Verification
The bench drives strobes held for a single cycle and for many cycles. A design that timed pulses from the strobe level would give a short pulse in the first case and a stretched or repeated one in the second. It also drives addresses one bit off the strap and a strap outside the all-ones space. A loose comparator would answer these with a stray load or enable. Status writes are checked for the absence of a data update or capture strobe, since a design that treated status like other registers would corrupt `wr_data`. A reset in the middle of the run checks that no select or timer state leaks past it.

// File: rtl/bus_regsel_pkg.sv
// Shared types for the bus register select interface.
// Assumes the two low word-address bits carry the register index.
package bus_regsel_pkg;

    // Register index as seen on address bits {2,1}
    typedef enum logic [1:0] {
        SEL_STAT = 2'b00,
        SEL_ADDR = 2'b01,
        SEL_BLEN = 2'b10,
        SEL_CTRL = 2'b11
    } reg_sel_e;

endpackage

// File: rtl/bus_sync.sv
// Two-stage level synchroniser, one chain per bit.
// Assumes inputs are levels that stay put for several clocks.
module bus_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // two-flop chain for bit i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end

endmodule

// File: rtl/bus_addr_dec.sv
// Address window compare and register index decode.
// Assumes the address is stable while the strobe is asserted.
module bus_addr_dec import bus_regsel_pkg::*; #(
    parameter int AW         = 16,
    parameter int SPACE_BITS = 4
) (
    input  logic [AW-1:1] addr,
    input  logic [AW-4:0] strap,
    output logic          hit,
    output reg_sel_e      sel
);

    localparam int SPACE_LO = AW - SPACE_BITS;

    // window match plus device-space check, then index decode
    always_comb begin
        hit = (addr[AW-1:3] == strap) && (&addr[AW-1:SPACE_LO]);
        sel = reg_sel_e'(addr[2:1]);
    end

endmodule

// File: rtl/bus_pulse_timer.sv
// Fixed-width pulse generator: a start request opens a window of
// PULSE_CYC cycles; a start during an open window restarts it.
// Assumes PULSE_CYC >= 1.
module bus_pulse_timer #(
    parameter int PULSE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic first
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt;

    // down-counter holding the remaining window length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(PULSE_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // marks the first cycle of a window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first <= 1'b0;
        end else begin
            first <= start;
        end
    end

    assign active = (cnt != '0);

endmodule

// File: rtl/bus_regsel_if.sv
// Slave register select for a block-transfer controller.
// Synchronises strobe and write, accepts a strobe on its rising edge
// when the address hits the strapped window, then drives a timed
// load or clear pulse for writes, or a held output enable for reads.
// Assumes address and data are stable for the whole strobe.
module bus_regsel_if import bus_regsel_pkg::*; #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int SPACE_BITS = 4,
    parameter int PULSE_CYC  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:1] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_wr_n,
    input  logic          bus_strb_n,
    input  logic [AW-4:0] strap_addr,
    output logic [DW-1:0] wr_data,
    output logic          ld_ctrl,
    output logic          ld_addr,
    output logic          ld_blen,
    output logic          cap_stb,
    output logic          clr_pulse,
    output logic          rd_stat_oe,
    output logic          rd_ctrl_oe,
    output logic          rd_addr_oe,
    output logic          rd_blen_oe
);

    logic [1:0] sync_d;
    logic [1:0] sync_q;
    logic       strb_s;
    logic       wr_s;
    logic       strb_d;
    logic       strb_rise;
    logic       hit;
    reg_sel_e   dec_sel;
    logic       accept;
    logic       sel_q;
    logic       wr_q;
    reg_sel_e   code_q;
    logic       tmr_active;
    logic       tmr_first;

    assign sync_d = {~bus_wr_n, ~bus_strb_n};

    bus_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_d),
        .q     (sync_q)
    );

    assign strb_s = sync_q[0];
    assign wr_s   = sync_q[1];

    bus_addr_dec #(.AW(AW), .SPACE_BITS(SPACE_BITS)) u_dec (
        .addr  (bus_addr),
        .strap (strap_addr),
        .hit   (hit),
        .sel   (dec_sel)
    );

    // delayed strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_d <= 1'b0;
        end else begin
            strb_d <= strb_s;
        end
    end

    assign strb_rise = strb_s & ~strb_d;
    assign accept    = strb_rise & hit;

    // select flop, direction and register index for the current strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            wr_q   <= 1'b0;
            code_q <= SEL_STAT;
        end else if (accept) begin
            sel_q  <= 1'b1;
            wr_q   <= wr_s;
            code_q <= dec_sel;
        end else if (!strb_s) begin
            sel_q  <= 1'b0;
        end
    end

    // data latch for writes to storing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data <= '0;
        end else if (accept && wr_s && (dec_sel != SEL_STAT)) begin
            wr_data <= bus_data;
        end
    end

    bus_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept & wr_s),
        .active (tmr_active),
        .first  (tmr_first)
    );

    // output steering by latched index and direction
    always_comb begin
        ld_ctrl    = tmr_active && wr_q && (code_q == SEL_CTRL);
        ld_addr    = tmr_active && wr_q && (code_q == SEL_ADDR);
        ld_blen    = tmr_active && wr_q && (code_q == SEL_BLEN);
        clr_pulse  = tmr_active && wr_q && (code_q == SEL_STAT);
        cap_stb    = tmr_first  && wr_q && (code_q != SEL_STAT);
        rd_stat_oe = sel_q && !wr_q && (code_q == SEL_STAT);
        rd_ctrl_oe = sel_q && !wr_q && (code_q == SEL_CTRL);
        rd_addr_oe = sel_q && !wr_q && (code_q == SEL_ADDR);
        rd_blen_oe = sel_q && !wr_q && (code_q == SEL_BLEN);
    end

endmodule

// File: rtl/bus_regsel_chk.sv
// Property checker for bus_regsel_if, attached by bind below.
// Assumes it sees the top module's ports only.
module bus_regsel_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] wr_data,
    input logic          ld_ctrl,
    input logic          ld_addr,
    input logic          ld_blen,
    input logic          cap_stb,
    input logic          clr_pulse,
    input logic          rd_stat_oe,
    input logic          rd_ctrl_oe,
    input logic          rd_addr_oe,
    input logic          rd_blen_oe
);

    logic       ld_any;
    logic [3:0] wr_vec;
    logic [3:0] rd_vec;

    assign ld_any = ld_ctrl | ld_addr | ld_blen;
    assign wr_vec = {ld_ctrl, ld_addr, ld_blen, clr_pulse};
    assign rd_vec = {rd_stat_oe, rd_ctrl_oe, rd_addr_oe, rd_blen_oe};

    // R3
    ld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    // R6
    rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_vec));

    // R6
    rd_wr_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|rd_vec) && (|wr_vec)));

    // R5
    cap_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> ld_any);

    // R5
    cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> !cap_stb);

    // R4
    clr_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> !cap_stb);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_any && !cap_stb) |-> $stable(wr_data));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!(|rd_vec) && !(|wr_vec) && !cap_stb && (wr_data == '0)));

endmodule

bind bus_regsel_if bus_regsel_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/bus_regsel_if_tb.sv
module bus_regsel_if_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 5;
    localparam logic [12:0] STRAP = 13'h1F35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_wr_n = 1'b1;
    logic        bus_strb_n = 1'b1;
    logic [12:0] strap_addr = STRAP;
    logic [15:0] wr_data;
    logic ld_ctrl, ld_addr, ld_blen, cap_stb, clr_pulse;
    logic rd_stat_oe, rd_ctrl_oe, rd_addr_oe, rd_blen_oe;

    int checks = 0;
    int errors = 0;
    int ld_cycles = 0;
    int any_cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_regsel_if #(.PULSE_CYC(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_wr_n(bus_wr_n), .bus_strb_n(bus_strb_n), .strap_addr(strap_addr),
        .wr_data(wr_data), .ld_ctrl(ld_ctrl), .ld_addr(ld_addr), .ld_blen(ld_blen),
        .cap_stb(cap_stb), .clr_pulse(clr_pulse), .rd_stat_oe(rd_stat_oe),
        .rd_ctrl_oe(rd_ctrl_oe), .rd_addr_oe(rd_addr_oe), .rd_blen_oe(rd_blen_oe)
    );

    // behavioural reference: sampled history queues and event state
    bit sq[$];
    bit wq[$];
    bit m_sel, m_wr, m_first;
    int m_code, m_cnt;
    logic [15:0] m_data;

    function automatic bit in_window(logic [15:1] a, logic [12:0] s);
        return (a[15:3] == s) && (a[15:12] == 4'hF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            sq = '{0, 0, 0, 0};
            wq = '{0, 0, 0, 0};
            m_sel = 0; m_wr = 0; m_first = 0; m_code = 0; m_cnt = 0; m_data = '0;
        end else begin
            bit rise;
            bit wr_now;
            rise   = sq[1] && !sq[2];
            wr_now = wq[1];
            if (m_cnt > 0) m_cnt--;
            m_first = 0;
            if (rise && in_window(bus_addr, strap_addr)) begin
                m_sel  = 1;
                m_wr   = wr_now;
                m_code = int'(bus_addr[2:1]);
                if (wr_now) begin
                    m_cnt   = PULSE;
                    m_first = 1;
                    if (m_code != 0) m_data = bus_data;
                end
            end else if (!sq[1]) begin
                m_sel = 0;
            end
            sq.push_front(!bus_strb_n);
            wq.push_front(!bus_wr_n);
            void'(sq.pop_back());
            void'(wq.pop_back());
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] e_ld, a_ld, e_rd, a_rd;
            e_ld = {m_cnt > 0 && m_wr && m_code == 3, m_cnt > 0 && m_wr && m_code == 1,
                    m_cnt > 0 && m_wr && m_code == 2, m_cnt > 0 && m_wr && m_code == 0};
            a_ld = {ld_ctrl, ld_addr, ld_blen, clr_pulse};
            e_rd = {m_sel && !m_wr && m_code == 0, m_sel && !m_wr && m_code == 3,
                    m_sel && !m_wr && m_code == 1, m_sel && !m_wr && m_code == 2};
            a_rd = {rd_stat_oe, rd_ctrl_oe, rd_addr_oe, rd_blen_oe};
            chk(a_ld[3:1] == e_ld[3:1], "R3 load lines", int'(a_ld[3:1]), int'(e_ld[3:1]));
            chk(a_ld[0] == e_ld[0], "R4 clear pulse", int'(a_ld[0]), int'(e_ld[0]));
            chk(cap_stb == (m_first && m_code != 0), "R5 capture strobe",
                int'(cap_stb), int'(m_first && m_code != 0));
            chk(a_rd == e_rd, "R6 read enables", int'(a_rd), int'(e_rd));
            chk(wr_data == m_data, "R8 data latch", int'(wr_data), int'(m_data));
            if (ld_ctrl || ld_addr || ld_blen) ld_cycles++;
            if ((|a_ld) || (|a_rd) || cap_stb) any_cycles++;
        end
    end

    task automatic bus_cycle(input logic [1:0] r, input logic [15:0] d, input bit wr, input int hold);
        @(negedge clk);
        bus_addr = {STRAP, r};
        bus_data = d;
        bus_wr_n = !wr;
        @(negedge clk);
        bus_strb_n = 1'b0;
        repeat (hold) @(negedge clk);
        bus_strb_n = 1'b1;
        repeat (PULSE + 6) @(negedge clk);
        bus_wr_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk({ld_ctrl, ld_addr, ld_blen, clr_pulse, cap_stb, rd_stat_oe, rd_ctrl_oe,
             rd_addr_oe, rd_blen_oe} == '0 && wr_data == '0, "R9 reset outputs", 0, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R10 reads of each register index
        bus_cycle(2'b00, 16'h1111, 0, 4);
        bus_cycle(2'b11, 16'h2222, 0, 6);
        bus_cycle(2'b01, 16'h3333, 0, 3);
        bus_cycle(2'b10, 16'h4444, 0, 8);

        // R3 R8 writes to storing registers
        bus_cycle(2'b11, 16'hA5A5, 1, 4);
        bus_cycle(2'b01, 16'h0F0F, 1, 4);
        bus_cycle(2'b10, 16'hC3C3, 1, 4);

        // R4 status write is a command: no data, clear pulse only
        bus_cycle(2'b00, 16'hDEAD, 1, 4);
        chk(wr_data == 16'hC3C3, "R4 status write keeps data", int'(wr_data), 16'hC3C3);

        // R7 long strobe: one window of PULSE cycles
        ld_cycles = 0;
        bus_cycle(2'b01, 16'h1234, 1, 25);
        chk(ld_cycles == PULSE, "R7 long strobe single pulse", ld_cycles, PULSE);

        // R7 one-cycle strobe still gives a full window
        ld_cycles = 0;
        bus_cycle(2'b11, 16'h5678, 1, 1);
        chk(ld_cycles == PULSE, "R7 short strobe full pulse", ld_cycles, PULSE);

        // R1 address one off the strap: nothing happens
        any_cycles = 0;
        strap_addr = STRAP ^ 13'h0001;
        bus_cycle(2'b01, 16'hBEEF, 1, 4);
        bus_cycle(2'b00, 16'hBEEF, 0, 4);
        chk(any_cycles == 0, "R1 mismatched address ignored", any_cycles, 0);
        chk(wr_data == 16'h5678, "R1 data untouched", int'(wr_data), 16'h5678);

        // R1 strap outside the all-ones space: nothing happens
        any_cycles = 0;
        strap_addr = 13'h0F35;
        @(negedge clk);
        bus_addr = {13'h0F35, 2'b11};
        bus_data = 16'h7777;
        bus_wr_n = 1'b0;
        @(negedge clk);
        bus_strb_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_strb_n = 1'b1;
        repeat (PULSE + 6) @(negedge clk);
        bus_wr_n = 1'b1;
        chk(any_cycles == 0, "R1 outside device space ignored", any_cycles, 0);
        strap_addr = STRAP;

        // R9 reset in mid-window
        bus_addr = {STRAP, 2'b10};
        bus_data = 16'h9999;
        bus_wr_n = 1'b0;
        @(negedge clk);
        bus_strb_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        bus_strb_n = 1'b1;
        bus_wr_n = 1'b1;
        @(negedge clk);
        chk({ld_ctrl, ld_addr, ld_blen, clr_pulse, cap_stb, rd_blen_oe} == '0 && wr_data == '0,
            "R9 mid-run reset", int'(wr_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R6 traffic after reset
        bus_cycle(2'b10, 16'h4321, 1, 3);
        bus_cycle(2'b00, 16'h0000, 0, 5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule